// File: doc/BRIEF.md
# Serial PCM Word Receiver with Frame Alignment

This block takes a companded voice sample that arrives as eight serial bits once per frame and turns it into a parallel byte. A bit clock marks each bit, and a frame-sync pulse marks where the word begins. Every input is sampled in the system clock domain through a two-stage synchronizer. Bits are taken on falling edges of the bit clock, sign bit first. Two framing rules are supported, chosen by a mode input. In the first, a sync pulse one bit period long is seen high at a falling edge. In the second, the sync pulse is several bit periods long and its rising edge starts the word. A second input chooses which of two bit clocks is used: the receive clock, or the transmit clock that is shared when both directions run from one timing source.

After the eighth bit the block shows the byte on its parallel output and pulses a valid strobe for one cycle. A fixed number of system-clock cycles later it pulses an update strobe. The downstream decoder uses this strobe to refresh its output, which models the short settling delay between the end of the slot and the new analog level. The selected bit clock must stay high and stay low for at least three system-clock cycles each.

Top module: `pcm_rx_deser`

## Requirements
- R1: While reset is asserted and in the cycle after it is released, word_out reads 0x00 and word_valid and update_stb are both 0.
- R2: With long_mode=0, a falling edge of the selected bit clock that finds fsync high starts a word. That edge captures no bit. The next eight falling edges capture sdata, and the first captured bit lands in word_out[7] (sign) and the last in word_out[0].
- R3: With long_mode=1, a rising edge of fsync starts a word. The next eight falling edges capture sdata in the same bit order as R2. The level of fsync at those edges has no effect.
- R4: word_valid is a one-cycle pulse, issued after the eighth captured bit, in the same cycle that word_out first shows the new word.
- R5: With sync_mode=1, tx_bclk is the bit clock and rx_bclk has no effect. With sync_mode=0, rx_bclk is the bit clock and tx_bclk has no effect.
- R6: A new start condition before the eighth bit discards the partial word and begins a fresh one. The discarded word produces no word_valid and does not change word_out. In short mode a sync-high edge is always a start, even where the eighth bit would have been taken.
- R7: word_out holds its value until the next complete word. Bit-clock edges with no start condition change neither word_out nor word_valid.
- R8: update_stb is a one-cycle pulse exactly UPD_CYCLES system-clock cycles after each word_valid.
- R9: If word_valid falls in the same cycle as the pending update_stb of the previous word, that strobe is still issued, and a new strobe follows UPD_CYCLES cycles after the new word_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_bclk | input | 1 | Receive bit clock |
| tx_bclk | input | 1 | Transmit bit clock, used when sync_mode=1 |
| sync_mode | input | 1 | 1 selects tx_bclk as the bit clock |
| long_mode | input | 1 | 0 selects the short framing rule, 1 the long rule |
| fsync | input | 1 | Frame-sync pulse |
| sdata | input | 1 | Serial data, sign bit first |
| word_out | output | 8 | Last complete word |
| word_valid | output | 1 | One-cycle pulse when word_out takes a new word |
| update_stb | output | 1 | Decoder-update pulse, UPD_CYCLES after word_valid |

## Verification
Two functions can land in the same cycle: the completion strobe of a new word, and the delayed update strobe still owed to the word before it. The bench provokes this by sending two short-sync frames back to back. With a bit period of eight system cycles, the two valid pulses are exactly nine bit periods apart, and the bench sets UPD_CYCLES to that spacing. It then checks three things: that one cycle carries both strobes, that every update strobe has a valid pulse exactly UPD_CYCLES cycles before it, and that the second word still receives its own strobe.

// File: rtl/pcm_rx_pkg.sv
package pcm_rx_pkg;

  // Append one serial bit at the LSB end; the first bit ends at the MSB.
  function automatic logic [7:0] shift_in(input logic [7:0] cur, input logic b);
    return {cur[6:0], b};
  endfunction

  // Next value of a down-counter that reloads on a load request.
  function automatic int unsigned tmr_next(input int unsigned cur,
                                           input logic load,
                                           input int unsigned reload);
    if (load) return reload;
    if (cur != 0) return cur - 1;
    return 0;
  endfunction

endpackage

// File: rtl/pcm_rx_edge.sv
module pcm_rx_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_bclk,
  input  logic tx_bclk,
  input  logic sync_mode,
  input  logic fsync,
  input  logic sdata,
  output logic bit_fall,
  output logic sync_lvl,
  output logic sync_rise,
  output logic data_bit
);
  localparam int NS = SYNC_STAGES;
  localparam int CK = 2;
  localparam int FS = 1;
  localparam int SD = 0;

  logic       bclk_sel;
  logic [2:0] raw;
  logic [NS:0][2:0] stg;

  assign bclk_sel = sync_mode ? tx_bclk : rx_bclk;
  assign raw      = {bclk_sel, fsync, sdata};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg <= '0;
    end else begin
      stg[0] <= raw;
      for (int i = 1; i <= NS; i++) stg[i] <= stg[i-1];
    end
  end

  assign bit_fall  = stg[NS][CK] & ~stg[NS-1][CK];
  assign sync_rise = stg[NS-1][FS] & ~stg[NS][FS];
  assign sync_lvl  = stg[NS-1][FS];
  assign data_bit  = stg[NS-1][SD];
endmodule

// File: rtl/pcm_rx_shift.sv
module pcm_rx_shift
  import pcm_rx_pkg::*;
#(
  parameter int WORD_BITS = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       long_mode,
  input  logic       bit_fall,
  input  logic       sync_lvl,
  input  logic       sync_rise,
  input  logic       data_bit,
  output logic [7:0] word_out,
  output logic       word_valid,
  output logic       frame_start
);
  localparam int CW = $clog2(WORD_BITS + 1);
  localparam logic [CW-1:0] LAST = CW'(WORD_BITS - 1);

  logic          active;
  logic [CW-1:0] cnt;
  logic [7:0]    sreg;
  logic [7:0]    nxt;

  assign frame_start = long_mode ? sync_rise : (bit_fall & sync_lvl);
  assign nxt         = shift_in(sreg, data_bit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active     <= 1'b0;
      cnt        <= '0;
      sreg       <= '0;
      word_out   <= '0;
      word_valid <= 1'b0;
    end else begin
      word_valid <= 1'b0;
      if (frame_start) begin
        active <= 1'b1;
        cnt    <= '0;
        sreg   <= '0;
      end else if (bit_fall && active) begin
        sreg <= nxt;
        cnt  <= cnt + 1'b1;
        if (cnt == LAST) begin
          word_out   <= nxt;
          word_valid <= 1'b1;
          active     <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/pcm_rx_upd_timer.sv
module pcm_rx_upd_timer
  import pcm_rx_pkg::*;
#(
  parameter int UPD_CYCLES = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic update_stb,
  output logic [$clog2(UPD_CYCLES+1)-1:0] tmr
);
  localparam int TW = $clog2(UPD_CYCLES + 1);

  always_ff @(posedge clk) begin
    if (!rst_n) tmr <= '0;
    else        tmr <= TW'(tmr_next(32'(tmr), load, UPD_CYCLES));
  end

  assign update_stb = (tmr == TW'(1));
endmodule

// File: rtl/pcm_rx_deser.sv
module pcm_rx_deser #(
  parameter int UPD_CYCLES  = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_bclk,
  input  logic       tx_bclk,
  input  logic       sync_mode,
  input  logic       long_mode,
  input  logic       fsync,
  input  logic       sdata,
  output logic [7:0] word_out,
  output logic       word_valid,
  output logic       update_stb
);
  localparam int TW = $clog2(UPD_CYCLES + 1);

  logic          bit_fall_w;
  logic          sync_lvl_w;
  logic          sync_rise_w;
  logic          data_bit_w;
  logic          frame_start_w;
  logic [TW-1:0] tmr_w;

  pcm_rx_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .rx_bclk(rx_bclk), .tx_bclk(tx_bclk),
    .sync_mode(sync_mode), .fsync(fsync), .sdata(sdata),
    .bit_fall(bit_fall_w), .sync_lvl(sync_lvl_w),
    .sync_rise(sync_rise_w), .data_bit(data_bit_w)
  );

  pcm_rx_shift #(.WORD_BITS(8)) u_shift (
    .clk(clk), .rst_n(rst_n), .long_mode(long_mode),
    .bit_fall(bit_fall_w), .sync_lvl(sync_lvl_w),
    .sync_rise(sync_rise_w), .data_bit(data_bit_w),
    .word_out(word_out), .word_valid(word_valid),
    .frame_start(frame_start_w)
  );

  pcm_rx_upd_timer #(.UPD_CYCLES(UPD_CYCLES)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(word_valid),
    .update_stb(update_stb), .tmr(tmr_w)
  );
endmodule

// File: rtl/pcm_rx_chk.sv
module pcm_rx_chk #(
  parameter int UPD_CYCLES = 20
) (
  input logic       clk,
  input logic       rst_n,
  input logic       bit_fall,
  input logic       frame_start,
  input logic       word_valid,
  input logic [7:0] word_out,
  input logic       update_stb,
  input logic [$clog2(UPD_CYCLES+1)-1:0] tmr
);
  localparam int TW = $clog2(UPD_CYCLES + 1);

  // R4
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> !word_valid);

  // R4
  valid_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> $past(bit_fall) && !$past(frame_start));

  // R7
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !word_valid |-> $stable(word_out));

  // R8
  tmr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(word_valid) |-> tmr == TW'(UPD_CYCLES));

  // R8
  upd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    update_stb |=> !update_stb);
endmodule

bind pcm_rx_deser pcm_rx_chk #(.UPD_CYCLES(UPD_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_fall(bit_fall_w),
  .frame_start(frame_start_w), .word_valid(word_valid),
  .word_out(word_out), .update_stb(update_stb), .tmr(tmr_w)
);

// File: tb/sim_pcm_rx_deser.sv
`timescale 1ns/1ps
module sim_pcm_rx_deser;
  localparam int D = 72;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_bclk = 1'b0, tx_bclk = 1'b0;
  logic sync_mode = 1'b0, long_mode = 1'b0;
  logic fsync = 1'b0, sdata = 1'b0;
  logic [7:0] word_out;
  logic word_valid, update_stb;

  int total = 0, bad = 0;
  int nvalid = 0, nupd = 0, nboth = 0, upd_err = 0;
  bit use_tx = 1'b0;
  bit done = 1'b0;
  logic [127:0] vh = '0;

  always #4 clk = ~clk;

  pcm_rx_deser #(.UPD_CYCLES(D)) u0 (
    .clk(clk), .rst_n(rst_n), .rx_bclk(rx_bclk), .tx_bclk(tx_bclk),
    .sync_mode(sync_mode), .long_mode(long_mode), .fsync(fsync),
    .sdata(sdata), .word_out(word_out), .word_valid(word_valid),
    .update_stb(update_stb)
  );

  // Monitor: counts strobes and checks the update spacing every cycle (R8)
  always @(negedge clk) begin
    if (rst_n) begin
      if (word_valid) nvalid++;
      if (update_stb) nupd++;
      if (word_valid && update_stb) nboth++;
      if (update_stb !== vh[D-1]) upd_err++;
      vh = {vh[126:0], word_valid};
    end else begin
      vh = '0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic set_clk(input logic v);
    if (use_tx) tx_bclk = v; else rx_bclk = v;
  endtask

  // One bit period of 8 system cycles: high 4, low 4
  task automatic bit_prd(input logic d, input logic fs);
    @(negedge clk);
    sdata = d; fsync = fs; set_clk(1'b1);
    repeat (4) @(negedge clk);
    set_clk(1'b0);
    repeat (3) @(negedge clk);
  endtask

  task automatic short_body(input logic [7:0] w);
    bit_prd(1'b0, 1'b1);
    for (int i = 7; i >= 0; i--) bit_prd(w[i], 1'b0);
  endtask

  task automatic long_body(input logic [7:0] w, input int fs_len);
    for (int i = 0; i < 8; i++) bit_prd(w[7-i], (i < fs_len) ? 1'b1 : 1'b0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) bit_prd(1'b0, 1'b0);
  endtask

  task automatic t_reset();
    chk(word_out == 8'h00, "R1 word_out", word_out, 0);
    chk(word_valid == 1'b0, "R1 word_valid", word_valid, 0);
    chk(update_stb == 1'b0, "R1 update_stb", update_stb, 0);
  endtask

  task automatic t_short(input logic [7:0] w);
    int n0 = nvalid;
    long_mode = 1'b0;
    short_body(w); idle(1);
    chk(word_out == w, "R2 short word", word_out, w);
    chk(nvalid == n0 + 1, "R4 one valid", nvalid - n0, 1);
  endtask

  task automatic t_long(input logic [7:0] w, input int fs_len);
    int n0 = nvalid;
    long_mode = 1'b1;
    long_body(w, fs_len); idle(1);
    chk(word_out == w, "R3 long word", word_out, w);
    chk(nvalid == n0 + 1, "R3 one valid", nvalid - n0, 1);
    long_mode = 1'b0;
  endtask

  task automatic t_clk_sel();
    int n0 = nvalid;
    logic [7:0] prev = word_out;
    sync_mode = 1'b1; use_tx = 1'b0;
    short_body(8'h81); idle(1);
    chk(word_out == prev, "R5 rx ignored word", word_out, prev);
    chk(nvalid == n0, "R5 rx ignored valid", nvalid - n0, 0);
    use_tx = 1'b1;
    short_body(8'h5A); idle(1);
    chk(word_out == 8'h5A, "R5 tx selected", word_out, 8'h5A);
    sync_mode = 1'b0; use_tx = 1'b0;
  endtask

  task automatic t_abort();
    int n0 = nvalid;
    long_mode = 1'b0;
    bit_prd(1'b0, 1'b1);
    for (int i = 0; i < 4; i++) bit_prd(1'b1, 1'b0);
    short_body(8'h0F); idle(1);
    chk(word_out == 8'h0F, "R6 short restart word", word_out, 8'h0F);
    chk(nvalid == n0 + 1, "R6 short restart valid", nvalid - n0, 1);
    n0 = nvalid;
    bit_prd(1'b0, 1'b1);
    for (int i = 0; i < 7; i++) bit_prd(1'b1, 1'b0);
    short_body(8'h42); idle(1);
    chk(word_out == 8'h42, "R6 sync on 8th edge", word_out, 8'h42);
    chk(nvalid == n0 + 1, "R6 sync on 8th edge valid", nvalid - n0, 1);
    n0 = nvalid;
    long_mode = 1'b1;
    bit_prd(1'b1, 1'b1); bit_prd(1'b1, 1'b1); bit_prd(1'b1, 1'b0);
    long_body(8'hC3, 3); idle(1);
    chk(word_out == 8'hC3, "R6 long restart word", word_out, 8'hC3);
    chk(nvalid == n0 + 1, "R6 long restart valid", nvalid - n0, 1);
    long_mode = 1'b0;
  endtask

  task automatic t_hold();
    int n0 = nvalid;
    logic [7:0] prev = word_out;
    for (int i = 0; i < 10; i++) bit_prd(i[0], 1'b0);
    chk(word_out == prev, "R7 hold word", word_out, prev);
    chk(nvalid == n0, "R7 no valid", nvalid - n0, 0);
  endtask

  task automatic t_update();
    int u0c = nupd;
    t_short(8'hE7);
    repeat (D + 10) @(negedge clk);
    chk(nupd == u0c + 1, "R8 one update", nupd - u0c, 1);
    chk(upd_err == 0, "R8 update spacing", upd_err, 0);
  endtask

  task automatic t_coincide();
    int u0c = nupd;
    int b0 = nboth;
    long_mode = 1'b0;
    short_body(8'h11);
    short_body(8'h22);
    idle(1);
    repeat (D + 10) @(negedge clk);
    chk(word_out == 8'h22, "R9 second word", word_out, 8'h22);
    chk(nboth == b0 + 1, "R9 same-cycle strobes", nboth - b0, 1);
    chk(nupd == u0c + 2, "R9 two updates", nupd - u0c, 2);
    chk(upd_err == 0, "R9 update spacing", upd_err, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_short(8'hA5);
    t_short(8'h3C);
    t_long(8'h96, 4);
    t_long(8'h01, 8);
    t_clk_sel();
    t_abort();
    t_hold();
    t_update();
    t_coincide();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule